// File: doc/BRIEF.md
# Carry-Chained Add and Index-Update Unit

A small scalar arithmetic unit for a 32-bit datapath. It keeps two bits of state between operations: a carry bit and a sticky overflow bit. A long unsigned addition can therefore be split into 32-bit pieces. The low words are added with the carry-setting add, and the next words are added with the carry-consuming add. The same unit also steps a circular-buffer pointer downwards, wrapping it to a programmed last index, and forms the sum of the four unsigned bytes of a word.

Each operation is presented for one cycle with `in_valid` high. The result is registered, so it appears on `res_data`, qualified by `res_valid`, on the clock edge after the request. The carry and overflow bits are updated on that same edge. The overflow bit stays set until `ovf_clr` is pulsed.

Top module: `cc_arith_unit`

## Requirements
- R1: After a synchronous reset, `res_data` is 0, `res_valid` is 0, `carry_flag` is 0 and `ovf_flag` is 0.
- R2: A request accepted on a rising edge with `in_valid` high has its result on `res_data`, with `res_valid` high, right after that edge. `res_valid` is low after any edge where `in_valid` was low, and `res_data` then keeps its last value.
- R3: With `op_sel` = 2'b00, the result is the low 32 bits of the unsigned sum of `opnd_a` and `opnd_b`. Bit 32 of that sum is stored into `carry_flag`.
- R4: With `op_sel` = 2'b01, both operands are sign-extended to 33 bits and added together with the stored carry, and the low 32 bits are returned. This operation leaves `carry_flag` unchanged.
- R5: With `op_sel` = 2'b01, `ovf_flag` is set when bits 31 and 32 of the 33-bit sum differ. Once set, it stays set until it is cleared.
- R6: `ovf_flag` is cleared on an edge where `ovf_clr` is high. If an overflowing `op_sel` = 2'b01 request is accepted on that same edge, the set wins.
- R7: With `op_sel` = 2'b10, `opnd_b[7:0]` is a decrement amount and `opnd_b[23:8]` is a last index; `opnd_b[31:24]` is ignored. If `opnd_a` is zero, the result is the last index zero-extended. Otherwise the result is `opnd_a` minus the decrement, modulo 2^32.
- R8: With `op_sel` = 2'b11, the result is the sum of the four zero-extended bytes of `opnd_a`, so bits 31:10 are zero. `opnd_b` is ignored.
- R9: Operations other than `op_sel` = 2'b00 leave `carry_flag` unchanged. Edges with `in_valid` low change neither flag, except for a clear by `ovf_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe, one request per cycle |
| op_sel | input | 2 | Operation select (00 add-set-carry, 01 add-with-carry, 10 index step, 11 byte sum) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| ovf_clr | input | 1 | Clears the sticky overflow bit |
| res_data | output | 32 | Registered result |
| res_valid | output | 1 | High for one cycle when `res_data` holds a new result |
| carry_flag | output | 1 | Stored carry bit |
| ovf_flag | output | 1 | Sticky overflow bit |

## Verification
Every result and both flags are due exactly one rising edge after the request is sampled. The driver applies each request on a falling edge and pushes the expected result and flag values into a queue. The monitor samples the outputs on the next falling edge, half a cycle after the registers load, and pops one queue entry for each cycle in which `res_valid` is high. A cycle with `res_valid` high and nothing queued, or leftover entries at the end, is counted as an error. Flag-only effects, such as a clear with no request, are checked on the falling edge after the clear is sampled.

// File: rtl/cc_pkg.sv
package cc_pkg;
  typedef enum logic [1:0] {
    OP_ADD_SETC = 2'd0,
    OP_ADD_USEC = 2'd1,
    OP_IDX_STEP = 2'd2,
    OP_BYTE_SUM = 2'd3
  } cc_op_e;
endpackage

// File: rtl/cc_adder.sv
// Both adds share the operands: an unsigned add and a sign-extended add
// with carry-in. Either one is picked by the top.
module cc_adder #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W:0]   usum,
  output logic [DATA_W:0]   ssum
);
  always_comb begin
    usum = {1'b0, a} + {1'b0, b};
    ssum = {a[DATA_W-1], a} + {b[DATA_W-1], b} + {{DATA_W{1'b0}}, cin};
  end
endmodule

// File: rtl/cc_index.sv
// Circular-buffer pointer step: it wraps to the last index at zero.
module cc_index #(
  parameter int DATA_W = 32,
  parameter int DEC_W  = 8,
  parameter int IDX_W  = 16
) (
  input  logic [DATA_W-1:0] ptr,
  input  logic [DEC_W-1:0]  step,
  input  logic [IDX_W-1:0]  last_idx,
  output logic [DATA_W-1:0] next_ptr
);
  always_comb begin
    if (ptr == '0)
      next_ptr = {{(DATA_W-IDX_W){1'b0}}, last_idx};
    else
      next_ptr = ptr - {{(DATA_W-DEC_W){1'b0}}, step};
  end
endmodule

// File: rtl/cc_bytesum.sv
// Reduction sum of the unsigned lanes of a word.
module cc_bytesum #(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int LANES = DATA_W / LANE_W,
  localparam int SUM_W = LANE_W + $clog2(LANES)
) (
  input  logic [DATA_W-1:0] word,
  output logic [SUM_W-1:0]  total
);
  logic [SUM_W-1:0] acc [0:LANES];
  assign acc[0] = '0;
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign acc[i+1] = acc[i] + {{(SUM_W-LANE_W){1'b0}}, word[i*LANE_W +: LANE_W]};
  end
  assign total = acc[LANES];
endmodule

// File: rtl/cc_arith_unit.sv
module cc_arith_unit
  import cc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int DEC_W  = 8,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        op_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic              ovf_clr,
  output logic [DATA_W-1:0] res_data,
  output logic              res_valid,
  output logic              carry_flag,
  output logic              ovf_flag
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int SUM_W = LANE_W + $clog2(LANES);
  localparam int IDX_LSB = DEC_W;

  cc_op_e op;
  assign op = cc_op_e'(op_sel);

  logic [DATA_W:0]   usum, ssum;
  logic [DATA_W-1:0] idx_next;
  logic [SUM_W-1:0]  bsum;
  logic [DATA_W-1:0] result_c;
  logic              wc_ovf;

  cc_adder #(.DATA_W(DATA_W)) u_add (
    .a(opnd_a), .b(opnd_b), .cin(carry_flag), .usum(usum), .ssum(ssum)
  );

  cc_index #(.DATA_W(DATA_W), .DEC_W(DEC_W), .IDX_W(IDX_W)) u_idx (
    .ptr(opnd_a), .step(opnd_b[DEC_W-1:0]),
    .last_idx(opnd_b[IDX_LSB +: IDX_W]), .next_ptr(idx_next)
  );

  cc_bytesum #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_bsum (
    .word(opnd_a), .total(bsum)
  );

  assign wc_ovf = ssum[DATA_W] ^ ssum[DATA_W-1];

  always_comb begin
    unique case (op)
      OP_ADD_SETC: result_c = usum[DATA_W-1:0];
      OP_ADD_USEC: result_c = ssum[DATA_W-1:0];
      OP_IDX_STEP: result_c = idx_next;
      default:     result_c = {{(DATA_W-SUM_W){1'b0}}, bsum};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_data   <= '0;
      res_valid  <= 1'b0;
      carry_flag <= 1'b0;
      ovf_flag   <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) res_data <= result_c;
      if (in_valid && op == OP_ADD_SETC) carry_flag <= usum[DATA_W];
      if (in_valid && op == OP_ADD_USEC && wc_ovf) ovf_flag <= 1'b1;
      else if (ovf_clr)                            ovf_flag <= 1'b0;
    end
  end

  // Assertions
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);
  assert_idle_no_result_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid && $stable(res_data));
  assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    ovf_flag && !ovf_clr |=> ovf_flag);
  assert_ovf_clear_R6: assert property (@(posedge clk) disable iff (rst)
    ovf_clr && !(in_valid && op_sel == 2'b01) |=> !ovf_flag);
  assert_carry_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && op_sel == 2'b00) |=> $stable(carry_flag));
  assert_wrap_to_last_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid && op_sel == 2'b10 && opnd_a == '0 |=>
      res_data == {{(DATA_W-IDX_W){1'b0}}, $past(opnd_b[IDX_LSB +: IDX_W])});
  assert_bytesum_narrow_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid && op_sel == 2'b11 |=> res_data[DATA_W-1:SUM_W] == '0);
endmodule

// File: tb/tb_cc_arith_unit.sv
`timescale 1ns/1ps
module tb_cc_arith_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic        ovf_clr = 1'b0;
  logic [31:0] res_data;
  logic        res_valid, carry_flag, ovf_flag;

  always #2 clk = ~clk;

  cc_arith_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .ovf_clr(ovf_clr),
    .res_data(res_data), .res_valid(res_valid),
    .carry_flag(carry_flag), .ovf_flag(ovf_flag)
  );

  typedef struct {
    logic [31:0] r;
    logic        c;
    logic        o;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  logic m_c = 1'b0;
  logic m_o = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: apply one request, predict it, queue the prediction
  task automatic issue(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic clr, input string tag);
    logic [32:0] w;
    logic [31:0] r;
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; op_sel = op; opnd_a = a; opnd_b = b; ovf_clr = clr;
    if (clr) m_o = 1'b0;
    case (op)
      2'b00: begin w = {1'b0, a} + {1'b0, b}; r = w[31:0]; m_c = w[32]; end
      2'b01: begin
        w = {a[31], a} + {b[31], b} + {32'b0, m_c};
        r = w[31:0];
        if (w[32] != w[31]) m_o = 1'b1;
      end
      2'b10: r = (a == 0) ? {16'b0, b[23:8]} : a - {24'b0, b[7:0]};
      default: r = {24'b0, a[7:0]} + {24'b0, a[15:8]} + {24'b0, a[23:16]} + {24'b0, a[31:24]};
    endcase
    e.r = r; e.c = m_c; e.o = m_o; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0; ovf_clr = 1'b0;
    end
  endtask

  task automatic check_flags(input string tag);
    chk(carry_flag == m_c, {tag, " carry"}, {31'b0, carry_flag}, {31'b0, m_c});
    chk(ovf_flag == m_o, {tag, " ovf"}, {31'b0, ovf_flag}, {31'b0, m_o});
  endtask

  // Monitor: compare each result half a cycle after it is registered
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && res_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected result", res_data, 32'h0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(res_data == e.r, e.tag, res_data, e.r);
          chk(carry_flag == e.c, {e.tag, " carry"}, {31'b0, carry_flag}, {31'b0, e.c});
          chk(ovf_flag == e.o, {e.tag, " ovf"}, {31'b0, ovf_flag}, {31'b0, e.o});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(res_data == 0 && !res_valid, "R1 reset result", res_data, 32'h0);
    chk(!carry_flag && !ovf_flag, "R1 reset flags", {30'b0, carry_flag, ovf_flag}, 32'h0);
    rst = 1'b0;

    // R3 unsigned add with carry out
    issue(2'b00, 32'hFFFF_FFFF, 32'h0000_0001, 1'b0, "R3 add carry out");
    // R4 carry-consuming add, carry kept
    issue(2'b01, 32'd5, 32'd7, 1'b0, "R4 add with carry in");
    issue(2'b00, 32'd1, 32'd2, 1'b0, "R3 add no carry");
    // R5 positive overflow, then sticky
    issue(2'b01, 32'h7FFF_FFFF, 32'h1, 1'b0, "R5 overflow set");
    issue(2'b01, 32'd1, 32'd1, 1'b0, "R5 overflow sticky");
    idle(2);
    // R2 no result while idle
    chk(!res_valid, "R2 idle valid", {31'b0, res_valid}, 32'h0);
    // R6 clear alone
    @(negedge clk); ovf_clr = 1'b1; m_o = 1'b0;
    idle(1);
    check_flags("R6 clear");
    // R6 set wins over clear
    issue(2'b01, 32'h8000_0000, 32'h8000_0000, 1'b1, "R6 set beats clear");
    issue(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R4 negative no overflow");
    // R7 index step
    issue(2'b10, 32'h0, 32'h0012_3405, 1'b0, "R7 wrap to last");
    issue(2'b10, 32'h10, 32'h0012_3405, 1'b0, "R7 decrement");
    issue(2'b10, 32'h3, 32'h0012_3405, 1'b0, "R7 decrement past zero");
    issue(2'b10, 32'h0, 32'hFF12_3405, 1'b0, "R7 top byte ignored");
    // R8 byte sum
    issue(2'b11, 32'hFFFF_FFFF, 32'h1234_5678, 1'b0, "R8 max byte sum");
    issue(2'b11, 32'h0102_0304, 32'hDEAD_BEEF, 1'b0, "R8 byte sum");
    // R9 carry survives other ops
    issue(2'b00, 32'h8000_0000, 32'h8000_0000, 1'b0, "R9 set carry");
    issue(2'b10, 32'h5, 32'h1, 1'b0, "R9 idx keeps carry");
    issue(2'b11, 32'h5, 32'h1, 1'b0, "R9 sum keeps carry");
    issue(2'b01, 32'h0, 32'h0, 1'b0, "R9 carry reaches add");
    idle(3);
    check_flags("R9 idle flags");
    // Mixed traffic
    for (int i = 0; i < 60; i++) begin
      logic [1:0] op;
      logic [31:0] a, b;
      op = 2'($urandom_range(0, 3));
      a = $urandom;
      b = $urandom;
      if (i % 7 == 0) a = 32'h0;
      issue(op, a, b, 1'(i % 11 == 0), "R4 R7 R8 mixed");
    end
    idle(3);
    chk(exp_q.size() == 0, "R2 results missing", 32'(exp_q.size()), 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule